// File: doc/BRIEF.md
# Readout Cycle Gating Controller

This block coordinates acquisition between two detector subsystems that share one master clock. On the generating side it takes an asynchronous beam-spill level and a vector of per-layer busy flags. It produces a readout-cycle level that is high only while the spill is present and no layer reports busy.

On the receiving side the same level is turned into one-cycle start and stop commands, one for each of its edges. A bunch-crossing counter runs while the cycle is active. The counter is advanced by a tick derived from the master clock through a programmable divide ratio. A divide of 20 suits a 50 MHz master with a 2.5 MHz crossing rate, and a divide of 160 suits a 40 MHz master with 250 kHz. The receiver's own busy line is accepted but deliberately plays no part.

Top module: `rc_gate`

## Requirements
- R1: Two master-clock edges after the synchronizers settle, `rc_out` is high exactly when the spill is high and the combined busy is low. Changes at the inputs therefore reach `rc_out` after three clock edges.
- R2: The combined busy is the OR of every bit of `layer_busy_in`, so any single bit set forces `rc_out` low.
- R3: Each rising edge of `rc_out` produces exactly one `start_pulse`, which is high in the cycle that follows the edge.
- R4: Each falling edge of `rc_out` produces exactly one `stop_pulse`, which is high in the cycle that follows the edge.
- R5: `rx_busy_in` has no effect on `rc_out`, `start_pulse`, `stop_pulse` or the counter.
- R6: `start_pulse` and `stop_pulse` are each one cycle wide, and they are never high in the same cycle.
- R7: A start clears the divider phase and `bx_count`. After that, `bx_count` advances by one every `BX_DIV` cycles while the cycle is active. `bx_tick` is high in the last cycle of each period, which is the cycle before `bx_count` advances.
- R8: After a stop, `bx_count` holds its value and `bx_tick` stays low until the next start.
- R9: If busy rises during a spill, `rc_out` falls, giving a stop. It rises again in the same spill once busy clears, giving a new start.
- R10: The synchronous active-high `rst` forces `rc_out` low and `bx_count` to zero. No start or stop is issued while reset is held or in the first cycle after it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| spill_in | input | 1 | Asynchronous beam-spill level |
| layer_busy_in | input | NUM_LAYERS | Asynchronous busy flags, one per layer |
| rx_busy_in | input | 1 | Receiver busy, accepted and ignored |
| rc_out | output | 1 | Readout-cycle level |
| start_pulse | output | 1 | One-cycle start command |
| stop_pulse | output | 1 | One-cycle stop command |
| bx_tick | output | 1 | Last cycle of each crossing period while active |
| bx_count | output | CNT_W | Bunch-crossing count |

## Verification
An input change reaches `rc_out` after three edges: two synchronizer stages and the output register. The matching start or stop pulse follows on the fourth edge. The bench therefore drives inputs on a falling edge and samples the level and the pulse tallies five falling edges later, so the last registered result is in place before it is read. The counter is timed from the falling edge at which the start pulse is seen. The clear lands one edge later, so the count reads zero through offset 20 and reads one at offset 21, with `bx_tick` high at offset 20 only. Hold and restart checks are taken after waits long enough to cover the three-edge path plus the pulse stage.

// File: rtl/rc_gate.sv
module rc_gate #(
  parameter int NUM_LAYERS = 4,
  parameter int BX_DIV     = 20,
  parameter int CNT_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  spill_in,
  input  logic [NUM_LAYERS-1:0] layer_busy_in,
  input  logic                  rx_busy_in,
  output logic                  rc_out,
  output logic                  start_pulse,
  output logic                  stop_pulse,
  output logic                  bx_tick,
  output logic [CNT_W-1:0]      bx_count
);

  localparam int PH_W = (BX_DIV > 1) ? $clog2(BX_DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(BX_DIV - 1);

  logic                  spill_m, spill_s;
  logic [NUM_LAYERS-1:0] busy_m, busy_s;
  logic                  rst_q, rc_prev, run_q;
  logic [PH_W-1:0]       phase;

  always_ff @(posedge clk) begin
    spill_m <= spill_in;
    spill_s <= spill_m;
    busy_m  <= layer_busy_in;
    busy_s  <= busy_m;
  end

  wire rc_next = spill_s & ~(|busy_s);

  always_ff @(posedge clk) begin
    if (rst) rc_out <= 1'b0;
    else     rc_out <= rc_next;
  end

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      rc_prev     <= 1'b0;
      start_pulse <= 1'b0;
      stop_pulse  <= 1'b0;
    end else begin
      rc_prev     <= rc_out;
      start_pulse <= rc_out & ~rc_prev & ~rst_q;
      stop_pulse  <= ~rc_out & rc_prev & ~rst_q;
    end
  end

  wire period_end = (phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      phase    <= '0;
      bx_count <= '0;
    end else if (start_pulse) begin
      run_q    <= 1'b1;
      phase    <= '0;
      bx_count <= '0;
    end else if (stop_pulse) begin
      run_q    <= 1'b0;
    end else if (run_q) begin
      if (period_end) begin
        phase    <= '0;
        bx_count <= bx_count + 1'b1;
      end else begin
        phase    <= phase + 1'b1;
      end
    end
  end

  assign bx_tick = run_q & ~stop_pulse & period_end;

  // R2
  busy_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (|busy_s) |=> !rc_out);

  // R3
  start_edge_chk: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> ($past(rc_out) && !$past(rc_out, 2)));

  // R4
  stop_edge_chk: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |-> (!$past(rc_out) && $past(rc_out, 2)));

  // R5
  rx_busy_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_busy_in && $rose(rc_out)) |=> start_pulse);

  // R6
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(start_pulse && stop_pulse));

  // R6
  start_width_chk: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !start_pulse);

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !start_pulse) |=> $stable(bx_count));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!start_pulse && !stop_pulse));

endmodule

// File: tb/test_rc_gate.sv
module test_rc_gate;
  localparam int NL = 4;
  localparam int DIV = 20;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spill = 1'b0;
  logic [NL-1:0] busy = '0;
  logic rxb = 1'b0;
  logic rc, st, sp, tick;
  logic [CW-1:0] cnt;

  int checks = 0, errors = 0;
  int start_cnt = 0, stop_cnt = 0, overlap = 0, wide = 0;
  logic prev_st = 1'b0, prev_sp = 1'b0;

  always #2 clk = ~clk;

  rc_gate #(.NUM_LAYERS(NL), .BX_DIV(DIV), .CNT_W(CW)) i_rc_gate (
    .clk(clk), .rst(rst), .spill_in(spill), .layer_busy_in(busy),
    .rx_busy_in(rxb), .rc_out(rc), .start_pulse(st), .stop_pulse(sp),
    .bx_tick(tick), .bx_count(cnt));

  always @(negedge clk) begin
    if (st) start_cnt++;
    if (sp) stop_cnt++;
    if (st && sp) overlap++;
    if ((st && prev_st) || (sp && prev_sp)) wide++;
    prev_st = st;
    prev_sp = sp;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // {spill, busy[3:0], rx_busy, expected rc}
  localparam logic [6:0] VEC [0:9] = '{
    7'b0_0000_0_0, 7'b1_0000_0_1, 7'b1_0001_0_0, 7'b1_1000_0_0,
    7'b1_0000_1_1, 7'b0_0100_1_0, 7'b1_0110_0_0, 7'b1_0000_0_1,
    7'b0_0000_0_0, 7'b1_0000_1_1};

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    logic prev_exp;
    int s0, p0, held;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(rc == 1'b0 && st == 1'b0 && sp == 1'b0, "R10 reset outputs", {rc, st, sp}, 0);
    chk(cnt == 0, "R10 reset count", cnt, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    prev_exp = 1'b0;
    for (int i = 0; i < 10; i++) begin
      s0 = start_cnt; p0 = stop_cnt;
      {spill, busy, rxb} = VEC[i][6:1];
      repeat (5) @(negedge clk);
      chk(rc == VEC[i][0], "R1 R2 R5 rc level", rc, VEC[i][0]);
      chk(start_cnt - s0 == int'(VEC[i][0] & ~prev_exp), "R3 start count", start_cnt - s0, VEC[i][0] & ~prev_exp);
      chk(stop_cnt - p0 == int'(~VEC[i][0] & prev_exp), "R4 stop count", stop_cnt - p0, ~VEC[i][0] & prev_exp);
      prev_exp = VEC[i][0];
    end

    // R7 counter timing from start
    spill = 1'b0; rxb = 1'b0; busy = '0;
    repeat (8) @(negedge clk);
    spill = 1'b1;
    for (int k = 0; k < 20 && !st; k++) @(negedge clk);
    chk(st == 1'b1, "R3 start seen", st, 1);
    repeat (20) @(negedge clk);
    chk(cnt == 0, "R7 count before first period", cnt, 0);
    chk(tick == 1'b1, "R7 tick at period end", tick, 1);
    @(negedge clk);
    chk(cnt == 1, "R7 count after first period", cnt, 1);
    chk(tick == 1'b0, "R7 tick one cycle", tick, 0);
    repeat (80) @(negedge clk);
    chk(cnt == 5, "R7 count after five periods", cnt, 5);

    // R8 hold after stop
    spill = 1'b0;
    repeat (12) @(negedge clk);
    held = cnt;
    repeat (60) @(negedge clk);
    chk(cnt == held, "R8 count held", cnt, held);
    chk(tick == 1'b0, "R8 tick quiet", tick, 0);

    // R7 restart clears
    spill = 1'b1;
    repeat (5) @(negedge clk);
    chk(cnt == 0, "R7 restart clears count", cnt, 0);

    // R9 busy mid-spill
    repeat (6) @(negedge clk);
    s0 = start_cnt; p0 = stop_cnt;
    busy = 4'b0100;
    repeat (5) @(negedge clk);
    chk(rc == 1'b0, "R9 rc drops on busy", rc, 0);
    chk(stop_cnt - p0 == 1, "R9 stop on busy", stop_cnt - p0, 1);
    busy = '0;
    repeat (5) @(negedge clk);
    chk(rc == 1'b1, "R9 rc returns", rc, 1);
    chk(start_cnt - s0 == 1, "R9 new start", start_cnt - s0, 1);

    // R10 reset while active
    repeat (30) @(negedge clk);
    s0 = start_cnt; p0 = stop_cnt;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(rc == 1'b0, "R10 rc low in reset", rc, 0);
    chk(cnt == 0, "R10 count zero in reset", cnt, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(start_cnt == s0 && stop_cnt == p0, "R10 no pulse around reset",
        (start_cnt - s0) + (stop_cnt - p0), 0);

    // R6
    chk(overlap == 0, "R6 no overlap", overlap, 0);
    chk(wide == 0, "R6 single-cycle pulses", wide, 0);
    finish_run();
  end
endmodule